// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a compact processor that completes one 32-bit instruction in every clock cycle. The program counter picks a word out of a small instruction array. A decoder turns the opcode and function fields into steering controls. The block holds 32 general registers. An arithmetic unit with a barrel shifter computes results. A word-wide data array serves loads and stores. Three fixed instruction layouts are handled: register-to-register, register-with-immediate, and absolute jump. Together they cover integer arithmetic and logic, shifts, comparisons, word loads and stores, two conditional branches, and jumps with or without a return link.

Both arrays are filled through a plain write strobe while the core is held in reset. This load port has no valid/ready pair and no back-pressure. Every strobed word is accepted on the rising edge where it appears. The core itself never stalls, so it offers no flow control either. Execution is observed at three output groups: the current fetch address, the register write-back port and the store port. Each group shows, during its own cycle, exactly what the instruction commits at the next rising edge.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 from the next rising edge on, and `wb_en` and `st_en` stay low. After release, the first fetch comes from address 0.
- R2: With opcode 0 (fields: opcode 31..26, rs 25..21, rt 20..16, rd 15..11, shift amount 10..6, function 5..0), the following function codes write rd with a 32-bit result: 32 and 33 give rs+rt, 34 and 35 give rs-rt, 36 gives AND, 37 gives OR, 38 gives XOR and 39 gives NOR. Sums and differences wrap silently and never trap.
- R3: Function codes 0, 2 and 3 shift rt left, logically right or arithmetically right by the shift-amount field. Codes 4, 6 and 7 do the same by the low 5 bits of rs. The result goes to rd.
- R4: Function 42 and opcode 10 write 1 or 0 for a signed less-than. Opcode 11 writes 1 or 0 for an unsigned less-than against the sign-extended immediate.
- R5: Opcodes 8 and 9 write rt with rs plus the sign-extended 16-bit immediate (bits 15..0). Opcodes 12, 13 and 14 write rt with rs AND, OR or XOR the zero-extended immediate.
- R6: Opcode 43 raises `st_en` with `st_addr` = rs + sign-extended immediate and `st_data` = rt. It writes no register. Opcode 35 writes rt with the data word at that address. Data words are indexed by address bits 7..2 in the default size, modulo the array depth.
- R7: Register 0 reads as zero. An instruction whose destination is register 0 leaves `wb_en` low.
- R8: Opcode 4 (equal) and opcode 5 (not equal) compare rs with rt. When taken, the next fetch address is PC+4 plus the sign-extended immediate times 4. Otherwise it is PC+4. Neither writes a register or memory.
- R9: Opcode 2 jumps to {(PC+4)[31:28], bits 25..0, 00}. Opcode 3 does the same and also writes PC+4 into register 31. Opcode 0 with function 8 jumps to the value of rs.
- R10: Any other opcode, or any other function code under opcode 0, only advances the PC by 4, with `wb_en` and `st_en` low.
- R11: Register and memory writes take effect on the rising edge. The instruction in the next cycle reads the new value with no extra delay.
- R12: With `load_en` high on a rising edge, `load_data` is written to word `load_addr` of the data array if `load_dmem` is 1, and of the instruction array if it is 0. Instructions are fetched by PC bits 7..2 in the default size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of PC and registers |
| load_en | input | 1 | Array preload strobe |
| load_dmem | input | 1 | Preload target: 1 data array, 0 instruction array |
| load_addr | input | LOAD_AW (6) | Preload word index |
| load_data | input | 32 | Preload word |
| pc_o | output | 32 | Byte address of the instruction executing this cycle |
| wb_en | output | 1 | Register write this cycle |
| wb_addr | output | 5 | Destination register |
| wb_data | output | 32 | Value written |
| st_en | output | 1 | Data store this cycle |
| st_addr | output | 32 | Store byte address |
| st_data | output | 32 | Stored word |

## Verification
The sweeps feed every operation signed extremes such as 0x80000000, 0x7FFFFFFF and all-ones. They also use immediates with bit 15 set and variable shift distances taken from registers whose upper bits are nonzero. A design that sign-extended the logical immediates, compared unsigned in the signed compare, or used all of rs as the shift distance would then write the wrong value. Destinations of register 0 and back-to-back dependencies appear throughout. Any leak through register 0, or a stale read of a value written one cycle earlier, would show up as a wrong write-back. A directed program takes and skips both branch kinds, calls and returns with a link, and executes an unknown opcode. An off-by-one branch offset, an unmasked upper PC, or a spurious write from the unknown opcode would each send the fetch address or the write-back port astray.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN     = 32;
  localparam int NUM_REGS = 32;
  localparam int RIDX_W   = $clog2(NUM_REGS);
  localparam int IMM_W    = 16;
  localparam int SH_W     = $clog2(XLEN);

  localparam logic [5:0] OP_REG   = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_JAL   = 6'd3;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_ADDIU = 6'd9;
  localparam logic [5:0] OP_SLTI  = 6'd10;
  localparam logic [5:0] OP_SLTIU = 6'd11;
  localparam logic [5:0] OP_ANDI  = 6'd12;
  localparam logic [5:0] OP_ORI   = 6'd13;
  localparam logic [5:0] OP_XORI  = 6'd14;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_SLL  = 6'd0;
  localparam logic [5:0] FN_SRL  = 6'd2;
  localparam logic [5:0] FN_SRA  = 6'd3;
  localparam logic [5:0] FN_SLLV = 6'd4;
  localparam logic [5:0] FN_SRLV = 6'd6;
  localparam logic [5:0] FN_SRAV = 6'd7;
  localparam logic [5:0] FN_JR   = 6'd8;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_ADDU = 6'd33;
  localparam logic [5:0] FN_SUB  = 6'd34;
  localparam logic [5:0] FN_SUBU = 6'd35;
  localparam logic [5:0] FN_AND  = 6'd36;
  localparam logic [5:0] FN_OR   = 6'd37;
  localparam logic [5:0] FN_XOR  = 6'd38;
  localparam logic [5:0] FN_NOR  = 6'd39;
  localparam logic [5:0] FN_SLT  = 6'd42;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA
  } alu_op_e;

  typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dst_sel_e;

  typedef struct packed {
    dst_sel_e dst;
    logic     src_imm;
    logic     imm_zext;
    logic     wb_mem;
    logic     wb_link;
    logic     reg_wr;
    logic     mem_wr;
    logic     br;
    logic     br_ne;
    logic     jmp;
    logic     jmp_reg;
    logic     sh_var;
    alu_op_e  alu;
  } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    case (opcode)
      OP_REG: begin
        ctrl.dst    = DST_RD;
        ctrl.reg_wr = 1'b1;
        case (funct)
          FN_SLL:  ctrl.alu = ALU_SLL;
          FN_SRL:  ctrl.alu = ALU_SRL;
          FN_SRA:  ctrl.alu = ALU_SRA;
          FN_SLLV: begin ctrl.alu = ALU_SLL; ctrl.sh_var = 1'b1; end
          FN_SRLV: begin ctrl.alu = ALU_SRL; ctrl.sh_var = 1'b1; end
          FN_SRAV: begin ctrl.alu = ALU_SRA; ctrl.sh_var = 1'b1; end
          FN_JR:   begin ctrl.reg_wr = 1'b0; ctrl.jmp_reg = 1'b1; end
          FN_ADD, FN_ADDU: ctrl.alu = ALU_ADD;
          FN_SUB, FN_SUBU: ctrl.alu = ALU_SUB;
          FN_AND:  ctrl.alu = ALU_AND;
          FN_OR:   ctrl.alu = ALU_OR;
          FN_XOR:  ctrl.alu = ALU_XOR;
          FN_NOR:  ctrl.alu = ALU_NOR;
          FN_SLT:  ctrl.alu = ALU_SLT;
          default: ctrl.reg_wr = 1'b0;
        endcase
      end
      OP_J:   ctrl.jmp = 1'b1;
      OP_JAL: begin
        ctrl.jmp = 1'b1; ctrl.reg_wr = 1'b1;
        ctrl.wb_link = 1'b1; ctrl.dst = DST_LINK;
      end
      OP_BEQ: begin ctrl.br = 1'b1; ctrl.alu = ALU_SUB; end
      OP_BNE: begin ctrl.br = 1'b1; ctrl.br_ne = 1'b1; ctrl.alu = ALU_SUB; end
      OP_ADDI, OP_ADDIU: begin
        ctrl.src_imm = 1'b1; ctrl.reg_wr = 1'b1; ctrl.alu = ALU_ADD;
      end
      OP_SLTI: begin
        ctrl.src_imm = 1'b1; ctrl.reg_wr = 1'b1; ctrl.alu = ALU_SLT;
      end
      OP_SLTIU: begin
        ctrl.src_imm = 1'b1; ctrl.reg_wr = 1'b1; ctrl.alu = ALU_SLTU;
      end
      OP_ANDI: begin
        ctrl.src_imm = 1'b1; ctrl.imm_zext = 1'b1; ctrl.reg_wr = 1'b1; ctrl.alu = ALU_AND;
      end
      OP_ORI: begin
        ctrl.src_imm = 1'b1; ctrl.imm_zext = 1'b1; ctrl.reg_wr = 1'b1; ctrl.alu = ALU_OR;
      end
      OP_XORI: begin
        ctrl.src_imm = 1'b1; ctrl.imm_zext = 1'b1; ctrl.reg_wr = 1'b1; ctrl.alu = ALU_XOR;
      end
      OP_LW: begin
        ctrl.src_imm = 1'b1; ctrl.reg_wr = 1'b1; ctrl.wb_mem = 1'b1; ctrl.alu = ALU_ADD;
      end
      OP_SW: begin
        ctrl.src_imm = 1'b1; ctrl.mem_wr = 1'b1; ctrl.alu = ALU_ADD;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [SW-1:0] sh,
  input  alu_op_e       op,
  output logic [W-1:0]  y,
  output logic          zero
);
  always_comb begin
    case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_XOR:  y = a ^ b;
      ALU_NOR:  y = ~(a | b);
      ALU_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLTU: y = {{(W-1){1'b0}}, (a < b)};
      ALU_SLL:  y = b << sh;
      ALU_SRL:  y = b >> sh;
      ALU_SRA:  y = $unsigned($signed(b) >>> sh);
      default:  y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W  = 32,
  parameter int N  = 32,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    if (g == 0) begin : g_const
      assign regs[g] = '0;
    end else begin : g_flop
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     q <= '0;
        else if (we && wa == AW'(g))    q <= wd;
      end
      assign regs[g] = q;
    end
  end

  assign rd_a = regs[ra];
  assign rd_b = regs[rb];
endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd = mem[ra];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int LOAD_AW    = $clog2((IMEM_WORDS > DMEM_WORDS) ? IMEM_WORDS : DMEM_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic               load_dmem,
  input  logic [LOAD_AW-1:0] load_addr,
  input  logic [XLEN-1:0]    load_data,
  output logic [XLEN-1:0]    pc_o,
  output logic               wb_en,
  output logic [RIDX_W-1:0]  wb_addr,
  output logic [XLEN-1:0]    wb_data,
  output logic               st_en,
  output logic [XLEN-1:0]    st_addr,
  output logic [XLEN-1:0]    st_data
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0]   pc_q, pc_nxt, pc_inc, br_tgt, j_tgt;
  logic [XLEN-1:0]   instr, rs_val, rt_val, imm_ext, alu_b, alu_y, dm_rd;
  logic [RIDX_W-1:0] f_rs, f_rt, f_rd;
  logic [SH_W-1:0]   shamt;
  logic [IMM_W-1:0]  imm;
  logic              alu_zero, br_take;
  ctrl_t             ctrl;

  // fetch
  sc_wordmem #(.W(XLEN), .DEPTH(IMEM_WORDS)) u_imem (
    .clk (clk),
    .we  (load_en && !load_dmem),
    .wa  (load_addr[IAW-1:0]),
    .wd  (load_data),
    .ra  (pc_q[IAW+1:2]),
    .rd  (instr)
  );

  assign f_rs = instr[25:21];
  assign f_rt = instr[20:16];
  assign f_rd = instr[15:11];
  assign imm  = instr[IMM_W-1:0];

  sc_decoder u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  sc_regfile #(.W(XLEN), .N(NUM_REGS)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra    (f_rs),
    .rb    (f_rt),
    .rd_a  (rs_val),
    .rd_b  (rt_val),
    .we    (wb_en),
    .wa    (wb_addr),
    .wd    (wb_data)
  );

  // execute
  assign imm_ext = ctrl.imm_zext ? {{(XLEN-IMM_W){1'b0}}, imm}
                                 : {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_val;
  assign shamt   = ctrl.sh_var ? rs_val[SH_W-1:0] : instr[10:6];

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .sh   (shamt),
    .op   (ctrl.alu),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: preload port has priority, used only while held in reset
  sc_wordmem #(.W(XLEN), .DEPTH(DMEM_WORDS)) u_dmem (
    .clk (clk),
    .we  (st_en || (load_en && load_dmem)),
    .wa  ((load_en && load_dmem) ? load_addr[DAW-1:0] : alu_y[DAW+1:2]),
    .wd  ((load_en && load_dmem) ? load_data : rt_val),
    .ra  (alu_y[DAW+1:2]),
    .rd  (dm_rd)
  );

  assign st_en   = rst_n && ctrl.mem_wr;
  assign st_addr = alu_y;
  assign st_data = rt_val;

  // write-back
  always_comb begin
    case (ctrl.dst)
      DST_RD:   wb_addr = f_rd;
      DST_LINK: wb_addr = RIDX_W'(NUM_REGS - 1);
      default:  wb_addr = f_rt;
    endcase
  end

  assign wb_en   = rst_n && ctrl.reg_wr && (wb_addr != '0);
  assign wb_data = ctrl.wb_link ? pc_inc : (ctrl.wb_mem ? dm_rd : alu_y);

  // next PC
  assign pc_inc  = pc_q + XLEN'(4);
  assign br_tgt  = pc_inc + {{(XLEN-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
  assign j_tgt   = {pc_inc[XLEN-1:XLEN-4], instr[25:0], 2'b00};
  assign br_take = ctrl.br && (alu_zero ^ ctrl.br_ne);

  always_comb begin
    if (ctrl.jmp_reg)  pc_nxt = rs_val;
    else if (ctrl.jmp) pc_nxt = j_tgt;
    else if (br_take)  pc_nxt = br_tgt;
    else               pc_nxt = pc_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_nxt;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc_o,
  input logic        wb_en,
  input logic [4:0]  wb_addr,
  input logic        st_en
);
  // R1: nothing is committed while reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!wb_en && !st_en));

  // R1: fetch restarts from address zero
  a_r1_pc_restart: assert property (@(posedge clk)
    !rst_n |=> (pc_o == 32'd0));

  // R7: register zero is never reported as written
  a_r7_no_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_addr != 5'd0));

  // R6: a store writes no register
  a_r6_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |-> !wb_en);

  // R6: a store is followed by the sequential fetch
  a_r6_store_falls_through: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |=> (pc_o == $past(pc_o) + 32'd4));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pc_o    (pc_o),
  .wb_en   (wb_en),
  .wb_addr (wb_addr),
  .st_en   (st_en)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        load_en = 1'b0;
  logic        load_dmem = 1'b0;
  logic [5:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] pc_o, wb_data, st_addr, st_data;
  logic        wb_en, st_en;
  logic [4:0]  wb_addr;

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] im [WORDS];
  logic [31:0] dm [WORDS];
  logic [31:0] rf [32];
  logic [31:0] mpc;
  logic [31:0] seed = 32'h1234_5678;
  int          prev_dest = 0;

  sc_core #(.IMEM_WORDS(WORDS), .DMEM_WORDS(WORDS)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_dmem (load_dmem),
    .load_addr (load_addr),
    .load_data (load_data),
    .pc_o      (pc_o),
    .wb_en     (wb_en),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data),
    .st_en     (st_en),
    .st_addr   (st_addr),
    .st_data   (st_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, got %0d expected 0 remaining cycles", 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input int sh, input int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] enc_j(input int op, input int idx);
    return {6'(op), 26'(idx)};
  endfunction

  function automatic logic [31:0] next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h (pc %h)", tag, what, act, exp, mpc);
    end
  endtask

  // reference model of one instruction, built from the requirements
  task automatic model_eval(output logic we, output logic [4:0] wa, output logic [31:0] wd,
                            output logic se, output logic [31:0] sa, output logic [31:0] sd,
                            output logic [31:0] npc, output string tag);
    logic [31:0] ins, a, b, p4, sx, zx;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, sh;
    ins = im[mpc[7:2]];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    sh = ins[10:6];  fn = ins[5:0];
    a = rf[rs]; b = rf[rt];
    p4 = mpc + 32'd4;
    sx = {{16{ins[15]}}, ins[15:0]};
    zx = {16'd0, ins[15:0]};
    we = 1'b0; wa = rt; wd = '0; se = 1'b0; sa = '0; sd = '0; npc = p4; tag = "R10";
    case (op)
      6'd0: begin
        wa = rd; we = 1'b1; tag = "R2";
        case (fn)
          6'd0:  begin wd = b << sh; tag = "R3"; end
          6'd2:  begin wd = b >> sh; tag = "R3"; end
          6'd3:  begin wd = $signed(b) >>> sh; tag = "R3"; end
          6'd4:  begin wd = b << a[4:0]; tag = "R3"; end
          6'd6:  begin wd = b >> a[4:0]; tag = "R3"; end
          6'd7:  begin wd = $signed(b) >>> a[4:0]; tag = "R3"; end
          6'd8:  begin we = 1'b0; npc = a; tag = "R9"; end
          6'd32, 6'd33: wd = a + b;
          6'd34, 6'd35: wd = a - b;
          6'd36: wd = a & b;
          6'd37: wd = a | b;
          6'd38: wd = a ^ b;
          6'd39: wd = ~(a | b);
          6'd42: begin wd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R4"; end
          default: begin we = 1'b0; tag = "R10"; end
        endcase
      end
      6'd2: begin npc = {p4[31:28], ins[25:0], 2'b00}; tag = "R9"; end
      6'd3: begin npc = {p4[31:28], ins[25:0], 2'b00}; we = 1'b1; wa = 5'd31; wd = p4; tag = "R9"; end
      6'd4: begin if (a == b) npc = p4 + (sx << 2); tag = "R8"; end
      6'd5: begin if (a != b) npc = p4 + (sx << 2); tag = "R8"; end
      6'd8, 6'd9: begin we = 1'b1; wd = a + sx; tag = "R5"; end
      6'd10: begin we = 1'b1; wd = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0; tag = "R4"; end
      6'd11: begin we = 1'b1; wd = (a < sx) ? 32'd1 : 32'd0; tag = "R4"; end
      6'd12: begin we = 1'b1; wd = a & zx; tag = "R5"; end
      6'd13: begin we = 1'b1; wd = a | zx; tag = "R5"; end
      6'd14: begin we = 1'b1; wd = a ^ zx; tag = "R5"; end
      6'd35: begin we = 1'b1; wd = dm[(a + sx) >> 2 & 32'd63]; tag = "R6"; end
      6'd43: begin se = 1'b1; sa = a + sx; sd = b; tag = "R6"; end
      default: tag = "R10";
    endcase
    if (we && wa == 5'd0) begin we = 1'b0; tag = "R7"; end
    else if (prev_dest != 0 && (int'(rs) == prev_dest || int'(rt) == prev_dest)) tag = "R11";
  endtask

  task automatic run_prog(input int ncyc);
    logic        ewe, ese;
    logic [4:0]  ewa;
    logic [31:0] ewd, esa, esd, enpc;
    string       tag;
    @(negedge clk);
    rst_n = 1'b0;
    // R12: preload both arrays while held in reset
    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_dmem = 1'b0; load_addr = 6'(i); load_data = im[i];
    end
    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_dmem = 1'b1; load_addr = 6'(i); load_data = dm[i];
    end
    @(negedge clk);
    load_en = 1'b0;
    #1;
    check(pc_o === 32'd0, "R1", "pc in reset", pc_o, 32'd0);
    check(wb_en === 1'b0, "R1", "wb_en in reset", 32'(wb_en), 32'd0);
    check(st_en === 1'b0, "R1", "st_en in reset", 32'(st_en), 32'd0);
    for (int r = 0; r < 32; r++) rf[r] = '0;
    mpc = '0;
    prev_dest = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      #1;
      model_eval(ewe, ewa, ewd, ese, esa, esd, enpc, tag);
      if (c == 0) tag = "R12";
      check(pc_o === mpc, tag, "fetch address", pc_o, mpc);
      check(wb_en === ewe, tag, "wb_en", 32'(wb_en), 32'(ewe));
      if (ewe) begin
        check(wb_addr === ewa, tag, "wb_addr", 32'(wb_addr), 32'(ewa));
        check(wb_data === ewd, tag, "wb_data", wb_data, ewd);
      end
      check(st_en === ese, tag, "st_en", 32'(st_en), 32'(ese));
      if (ese) begin
        check(st_addr === esa, tag, "st_addr", st_addr, esa);
        check(st_data === esd, tag, "st_data", st_data, esd);
      end
      if (ewe) rf[ewa] = ewd;
      if (ese) dm[esa[7:2]] = esd;
      prev_dest = ewe ? int'(ewa) : 0;
      mpc = enpc;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] gen_instr(input int n, input int k);
    int rfn [15] = '{0, 2, 3, 4, 6, 7, 32, 33, 34, 35, 36, 37, 38, 39, 42};
    int iop [7]  = '{8, 9, 10, 11, 12, 13, 14};
    int bop [4]  = '{1, 6, 15, 63};
    int bfn [4]  = '{1, 5, 13, 63};
    int spc [4]  = '{32'h8000, 32'hFFFF, 32'h7FFF, 0};
    int sel, rs, rt, d, imm, sh;
    logic [31:0] r;
    r   = next_rand();
    sel = (k * 7 + n * 3) % 26;
    rs  = (k * 5 + n) % 31;
    rt  = (k * 3 + n * 7 + 1) % 31;
    d   = ((k + n) % 23 == 0) ? 0 : 8 + (k + n) % 23;
    imm = (k % 4 == 0) ? spc[n % 4] : int'(r[15:0]);
    sh  = (k * 3 + n) % 32;
    if (sel < 15)       return enc_r(rs, rt, d, (sel < 6) ? sh : 0, rfn[sel]);
    else if (sel < 22)  return enc_i(iop[sel-15], rs, d, imm);
    else if (sel == 22) return enc_i(35, 0, d, int'({r[15:2], 2'b00}));
    else if (sel == 23) return enc_i(43, 0, rt, int'({r[15:2], 2'b00}));
    else if (sel == 24) return enc_i(bop[n % 4], rs, d, imm);
    else                return enc_r(rs, rt, d, 0, bfn[n % 4]);
  endfunction

  initial begin
    #1 rst_n = 1'b0;

    // sweep: R2 R3 R4 R5 R6 R7 R10 R11 over many operand values
    for (int n = 0; n < 40; n++) begin
      dm[0] = 32'd0; dm[1] = 32'd1; dm[2] = 32'hFFFF_FFFF;
      dm[3] = 32'h8000_0000; dm[4] = 32'h7FFF_FFFF;
      for (int i = 5; i < WORDS; i++) dm[i] = next_rand();
      for (int r = 1; r <= 8; r++) im[r-1] = enc_i(35, 0, r, 4 * ((r - 1 + n) % 8));
      for (int k = 8; k < WORDS; k++) im[k] = gen_instr(n, k);
      run_prog(WORDS);
    end

    // directed control flow: R8 R9 with R7 R11 R6 R10 along the way
    for (int i = 0; i < WORDS; i++) begin im[i] = '0; dm[i] = '0; end
    dm[0] = 32'd5; dm[1] = 32'd5;
    im[0]  = enc_i(35, 0, 1, 0);
    im[1]  = enc_i(35, 0, 2, 4);
    im[2]  = enc_i(4, 1, 2, 3);
    im[3]  = enc_i(8, 0, 3, 1);
    im[4]  = enc_i(8, 0, 3, 2);
    im[6]  = enc_i(5, 1, 2, 5);
    im[7]  = enc_i(4, 1, 0, 1);
    im[8]  = enc_j(3, 12);
    im[9]  = enc_r(5, 5, 6, 0, 32);
    im[10] = enc_j(2, 14);
    im[12] = enc_i(8, 31, 5, 0);
    im[13] = enc_r(31, 0, 0, 0, 8);
    im[14] = enc_i(8, 0, 0, 7);
    im[15] = enc_r(0, 1, 7, 0, 32);
    im[16] = enc_i(43, 0, 7, 8);
    im[17] = enc_i(35, 0, 8, 8);
    im[18] = enc_i(63, 1, 9, 16'h1234);
    im[19] = enc_i(5, 1, 0, -20);
    run_prog(60);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule